// File: doc/BRIEF.md
# Interrupt Status with Read-Clear

This block keeps a bank of interrupt status flags together with a matching bank of enable bits, and drives an active-low interrupt request line. Each event pulse sets its flag, and the flag stays set until software clears it. The request line is pulled low while any set flag is also enabled.

Software reads the flags through a byte-wide serial transfer. The serial shifter itself lives outside this block. It passes in only the decoded address of the command byte and two single-cycle strobes. The first strobe marks the last SCLK falling edge of the command byte. The second marks the moment the last bit of the following data byte has been shifted out.

A plain status read only samples the flags. A read-with-reset samples the flags and later clears exactly the bits it sampled, so an event arriving during the transfer is never lost. Over a read-with-reset, the request line is held inactive from the end of the command byte until the data byte completes.

Top module: `irq_status_ctl`

## Requirements
- R1: An event pulse on bit i sets status flag i one clock later, whatever the value of enable bit i.
- R2: Outside a read-with-reset window, `irq_n_o` is 0 exactly when some flag bit and the enable bit at the same position are both 1.
- R3: After reset, all flags and enables are 0, `irq_n_o` is 1 and `rd_data_o` is 0.
- R4: A command strobe with address 0x04 copies the flags into `rd_data_o`. This plain read leaves the flags and `irq_n_o` unchanged.
- R5: A command strobe with address 0x05 copies the flags into `rd_data_o`. `irq_n_o` is then 1 from the clock after that strobe through the clock of the data-done strobe, even if events arrive in between.
- R6: At the data-done strobe of a read-with-reset, only the flags copied at the command strobe are cleared. Flags set at or after that command strobe remain, and `irq_n_o` goes low again if any of them is enabled.
- R7: When an event on a bit coincides with the clear of that same bit, the flag stays set.
- R8: A command strobe with any address other than 0x04 or 0x05 leaves `rd_data_o`, the flags and `irq_n_o` unchanged.
- R9: An enable write loads all enable bits in one clock, and `irq_n_o` follows the new enables from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NFLAG | Event pulses, one bit per flag |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NFLAG | Enable register write value |
| xfer_addr_i | input | ADDR_W | Decoded address of the current command byte |
| cmd_done_i | input | 1 | Command byte complete (last SCLK falling edge) |
| data_done_i | input | 1 | Last bit of the data byte shifted out |
| rd_data_o | output | NFLAG | Status byte captured at the command strobe |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest cases are events that land inside a read-with-reset. One such event coincides with the command strobe and must be left out of the copy. Another coincides with the data-done strobe on a bit that is being cleared and must survive. The bench drives these with the event input aligned, in the same clock, to one strobe or the other. It then reveals the surviving flags through a following plain read and through the level of the request line.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_PLAIN = 2'd1,
        RS_CLR   = 2'd2
    } rd_state_e;

    localparam int unsigned DEF_NFLAG     = 8;
    localparam int unsigned DEF_ADDR_W    = 8;
    localparam int unsigned DEF_STAT_ADDR = 4;
    localparam int unsigned DEF_RCLR_ADDR = 5;

endpackage

// File: rtl/irqs_flags.sv
module irqs_flags #(
    parameter int unsigned NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic             en_we_i,
    input  logic [NFLAG-1:0] en_wdata_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] en_o
);

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] en;
    } flag_regs_t;

    flag_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NFLAG; i++) begin
            // a set on the same bit takes priority over its clear
            regs_d.flags[i] = evt_i[i] | (regs_q.flags[i] & ~clr_i[i]);
        end
        if (en_we_i) begin
            regs_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign flags_o = regs_q.flags;
    assign en_o    = regs_q.en;

endmodule

// File: rtl/irqs_rdctl.sv
module irqs_rdctl
    import irqs_pkg::*;
#(
    parameter int unsigned NFLAG     = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned STAT_ADDR = 4,
    parameter int unsigned RCLR_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cmd_done_i,
    input  logic              data_done_i,
    input  logic [NFLAG-1:0]  flags_i,
    output rd_state_e         state_o,
    output logic [NFLAG-1:0]  snap_o,
    output logic [NFLAG-1:0]  clr_o,
    output logic              hold_o
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] RCLR_A = ADDR_W'(RCLR_ADDR);

    typedef struct packed {
        rd_state_e        state;
        logic [NFLAG-1:0] snap;
    } rd_regs_t;

    rd_regs_t regs_d, regs_q;
    logic [NFLAG-1:0] clr_d;

    always_comb begin
        regs_d = regs_q;
        clr_d  = '0;
        unique case (regs_q.state)
            RS_IDLE: begin
                if (cmd_done_i) begin
                    if (addr_i == RCLR_A) begin
                        regs_d.state = RS_CLR;
                        regs_d.snap  = flags_i;
                    end else if (addr_i == STAT_A) begin
                        regs_d.state = RS_PLAIN;
                        regs_d.snap  = flags_i;
                    end
                end
            end
            RS_PLAIN: begin
                if (data_done_i) begin
                    regs_d.state = RS_IDLE;
                end
            end
            RS_CLR: begin
                if (data_done_i) begin
                    regs_d.state = RS_IDLE;
                    clr_d        = regs_q.snap;
                end
            end
            default: regs_d.state = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: RS_IDLE, snap: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign snap_o  = regs_q.snap;
    assign clr_o   = clr_d;
    assign hold_o  = (regs_q.state == RS_CLR);

endmodule

// File: rtl/irqs_irqgen.sv
module irqs_irqgen #(
    parameter int unsigned NFLAG = 8
) (
    input  logic [NFLAG-1:0] flags_i,
    input  logic [NFLAG-1:0] en_i,
    input  logic             hold_i,
    output logic             irq_n_o
);

    logic [NFLAG-1:0] pend;

    for (genvar g = 0; g < NFLAG; g++) begin : g_pend
        assign pend[g] = flags_i[g] & en_i[g];
    end

    assign irq_n_o = hold_i | ~(|pend);

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irqs_pkg::*;
#(
    parameter int unsigned NFLAG     = DEF_NFLAG,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned STAT_ADDR = DEF_STAT_ADDR,
    parameter int unsigned RCLR_ADDR = DEF_RCLR_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  evt_i,
    input  logic              en_we_i,
    input  logic [NFLAG-1:0]  en_wdata_i,
    input  logic [ADDR_W-1:0] xfer_addr_i,
    input  logic              cmd_done_i,
    input  logic              data_done_i,
    output logic [NFLAG-1:0]  rd_data_o,
    output logic              irq_n_o
);

    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] en_q;
    logic [NFLAG-1:0] snap_q;
    logic [NFLAG-1:0] clr_mask;
    logic             hold;
    rd_state_e        rd_state_q;

    irqs_flags #(.NFLAG(NFLAG)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_i      (clr_mask),
        .en_we_i    (en_we_i),
        .en_wdata_i (en_wdata_i),
        .flags_o    (flags_q),
        .en_o       (en_q)
    );

    irqs_rdctl #(
        .NFLAG     (NFLAG),
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .RCLR_ADDR (RCLR_ADDR)
    ) u_rdctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (xfer_addr_i),
        .cmd_done_i  (cmd_done_i),
        .data_done_i (data_done_i),
        .flags_i     (flags_q),
        .state_o     (rd_state_q),
        .snap_o      (snap_q),
        .clr_o       (clr_mask),
        .hold_o      (hold)
    );

    irqs_irqgen #(.NFLAG(NFLAG)) u_irqgen (
        .flags_i (flags_q),
        .en_i    (en_q),
        .hold_i  (hold),
        .irq_n_o (irq_n_o)
    );

    assign rd_data_o = snap_q;

endmodule

// File: rtl/irqs_chk.sv
module irqs_chk
    import irqs_pkg::*;
#(
    parameter int unsigned NFLAG     = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned RCLR_ADDR = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NFLAG-1:0]  evt_i,
    input logic              en_we_i,
    input logic [NFLAG-1:0]  en_wdata_i,
    input logic [ADDR_W-1:0] xfer_addr_i,
    input logic              cmd_done_i,
    input logic              data_done_i,
    input logic              irq_n_o,
    input logic [NFLAG-1:0]  flags_q,
    input logic [NFLAG-1:0]  en_q,
    input logic [NFLAG-1:0]  snap_q,
    input rd_state_e         rd_state_q
);

    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

    // R2
    irq_low_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state_q != RS_CLR && (|(flags_q & en_q))) |-> !irq_n_o);

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state_q == RS_IDLE && cmd_done_i && xfer_addr_i == ADDR_W'(RCLR_ADDR))
        |=> irq_n_o);

    // R6
    clear_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state_q == RS_CLR && data_done_i)
        |=> ((flags_q & $past(snap_q) & ~$past(evt_i)) == '0));

    // R4
    plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state_q == RS_PLAIN)
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R9
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_q == $past(en_wdata_i)));

endmodule

bind irq_status_ctl irqs_chk #(
    .NFLAG     (NFLAG),
    .ADDR_W    (ADDR_W),
    .RCLR_ADDR (RCLR_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .xfer_addr_i (xfer_addr_i),
    .cmd_done_i  (cmd_done_i),
    .data_done_i (data_done_i),
    .irq_n_o     (irq_n_o),
    .flags_q     (flags_q),
    .en_q        (en_q),
    .snap_q      (snap_q),
    .rd_state_q  (rd_state_q)
);

// File: tb/irq_status_ctl_tb.sv
`timescale 1ns/1ps
module irq_status_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       en_we_i = 1'b0;
    logic [7:0] en_wdata_i = '0;
    logic [7:0] xfer_addr_i = '0;
    logic       cmd_done_i = 1'b0;
    logic       data_done_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_n_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    irq_status_ctl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .en_we_i     (en_we_i),
        .en_wdata_i  (en_wdata_i),
        .xfer_addr_i (xfer_addr_i),
        .cmd_done_i  (cmd_done_i),
        .data_done_i (data_done_i),
        .rd_data_o   (rd_data_o),
        .irq_n_o     (irq_n_o)
    );

    // {event mask, enable mask, expected irq_n}
    localparam logic [16:0] VEC [6] = '{
        {8'h01, 8'h01, 1'b0},
        {8'h80, 8'h7F, 1'b1},
        {8'h3C, 8'h04, 1'b0},
        {8'hFF, 8'h00, 1'b1},
        {8'hA5, 8'h5A, 1'b1},
        {8'h00, 8'hFF, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        @(negedge clk) evt_i = m;
        @(negedge clk) evt_i = '0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        @(negedge clk) begin en_we_i = 1'b1; en_wdata_i = v; end
        @(negedge clk) en_we_i = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] a);
        @(negedge clk) begin xfer_addr_i = a; cmd_done_i = 1'b1; end
        @(negedge clk) cmd_done_i = 1'b0;
    endtask

    task automatic dat();
        @(negedge clk) data_done_i = 1'b1;
        @(negedge clk) data_done_i = 1'b0;
    endtask

    task automatic plain_read(output logic [7:0] v);
        cmd(8'h04);
        v = rd_data_o;
        dat();
    endtask

    task automatic clear_all();
        cmd(8'h05);
        dat();
    endtask

    initial begin
        #900000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 irq", {7'd0, irq_n_o}, 8'h01);
        chk("R3 rd_data", rd_data_o, 8'h00);
        plain_read(v);
        chk("R3 flags", v, 8'h00);

        // table walk: R1 R2 R5 R6
        for (int i = 0; i < 6; i++) begin
            wr_en(VEC[i][8:1]);
            pulse_evt(VEC[i][16:9]);
            chk("R2 irq level", {7'd0, irq_n_o}, {7'd0, VEC[i][0]});
            cmd(8'h05);
            chk("R5 irq held high", {7'd0, irq_n_o}, 8'h01);
            chk("R1 captured flags", rd_data_o, VEC[i][16:9]);
            dat();
            chk("R6 irq after clear", {7'd0, irq_n_o}, 8'h01);
            plain_read(v);
            chk("R6 flags cleared", v, 8'h00);
        end

        // R4 plain read keeps flags and irq
        wr_en(8'h01);
        pulse_evt(8'h01);
        cmd(8'h04);
        chk("R4 irq during plain read", {7'd0, irq_n_o}, 8'h00);
        chk("R4 rd_data", rd_data_o, 8'h01);
        dat();
        chk("R4 irq after plain read", {7'd0, irq_n_o}, 8'h00);
        plain_read(v);
        chk("R4 flags kept", v, 8'h01);

        // R5/R6 event during read-with-reset
        wr_en(8'h03);
        cmd(8'h05);
        chk("R5 irq high in window", {7'd0, irq_n_o}, 8'h01);
        pulse_evt(8'h02);
        chk("R5 irq still high", {7'd0, irq_n_o}, 8'h01);
        dat();
        chk("R6 irq low again", {7'd0, irq_n_o}, 8'h00);
        plain_read(v);
        chk("R6 late event kept", v, 8'h02);
        clear_all();

        // R6 event in the same clock as the command strobe
        @(negedge clk) begin xfer_addr_i = 8'h05; cmd_done_i = 1'b1; evt_i = 8'h08; end
        @(negedge clk) begin cmd_done_i = 1'b0; evt_i = '0; end
        chk("R6 snapshot excludes same-cycle event", rd_data_o, 8'h00);
        dat();
        plain_read(v);
        chk("R6 same-cycle event survives", v, 8'h08);
        clear_all();

        // R7 set beats clear on one bit
        pulse_evt(8'h04);
        cmd(8'h05);
        @(negedge clk) begin data_done_i = 1'b1; evt_i = 8'h04; end
        @(negedge clk) begin data_done_i = 1'b0; evt_i = '0; end
        plain_read(v);
        chk("R7 set wins", v, 8'h04);
        clear_all();

        // R8 unknown address
        wr_en(8'h10);
        pulse_evt(8'h10);
        plain_read(v);
        cmd(8'h06);
        chk("R8 irq unchanged", {7'd0, irq_n_o}, 8'h00);
        chk("R8 rd_data unchanged", rd_data_o, 8'h10);
        dat();
        plain_read(v);
        chk("R8 flags unchanged", v, 8'h10);
        clear_all();

        // R9 enable write
        wr_en(8'h00);
        pulse_evt(8'h20);
        chk("R9 disabled irq", {7'd0, irq_n_o}, 8'h01);
        wr_en(8'h20);
        chk("R9 enabled irq", {7'd0, irq_n_o}, 8'h00);
        wr_en(8'h00);
        chk("R9 re-disabled irq", {7'd0, irq_n_o}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule